// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Address-Space Tags

This block turns a 14-bit virtual address into a 12-bit physical address using a small cache of recent page mappings. The cache has 4 sets of 4 ways. Every entry carries the identifier of the address space it belongs to, so mappings of several processes can coexist and nothing needs flushing on a context switch. A lookup is answered in the same cycle as the request. The answer is exactly one of three results:
- a translation,
- a miss, which tells the page-table walker to fetch the mapping,
- a protection fault, when the stored permissions forbid the access.

The walker writes mappings back through a fill port. A fill takes effect at the next clock edge. When a set is full, the victim is picked by a selectable policy: least recently used or pseudo-random. A separate invalidate command removes either every entry or only the entries of one address space.

The lookup channel never back-pressures: `lk_ready` is held high and a request is taken in every cycle where `lk_valid` is high. The fill channel is valid/ready. A fill is accepted at a rising edge when `fill_valid` and `fill_ready` are both high. `fill_ready` drops in every cycle where an invalidate is requested, so an invalidate always wins over a fill. The walker must then hold its fill until `fill_ready` returns.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup with `lk_valid` high reports a miss.
- R2: Virtual address bits [5:0] are the page offset. Bits [7:6] select the set and bits [13:8] are the tag. On a hit, `rsp_pa` equals the stored 6-bit page number followed by the unchanged offset. For example, VA 0x03D7 with stored page number 0x0D gives PA 0x357.
- R3: A hit requires both the tag and the 8-bit address-space identifier to match. The same virtual page can be held under two identifiers at once, each with its own page number.
- R4: The fill permission field is [2] supervisor-only, [1] write allowed, [0] read allowed. A matching lookup raises `rsp_fault` instead of `rsp_hit` when any of these holds:
  - `lk_user`=1 and supervisor-only is set;
  - `lk_write`=1 and write is not allowed;
  - `lk_write`=0 and read is not allowed.
- R5: `lk_ready` is always 1. While `lk_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. While `lk_valid` is low, none of them is high.
- R6: An accepted fill is visible to lookups from the next cycle. A fill whose tag and identifier already sit in the set overwrites that entry in place and leaves no duplicate.
- R7: A fill into a set that has an invalid way uses the lowest-numbered invalid way and evicts nothing.
- R8: With `repl_random`=0, a fill into a full set replaces the least recently used way. Both hits and fills count as uses.
- R9: With `repl_random`=1, a fill into a full set replaces a way chosen by a free-running LFSR. Exactly one earlier entry of that set is lost and the new one hits.
- R10: An invalidate with `inv_all`=1 removes every entry.
- R11: An invalidate with `inv_all`=0 removes only the entries whose identifier equals `inv_asid`.
- R12: `fill_ready` is low while `inv_valid` is high, and a fill offered in that cycle is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| repl_random | input | 1 | Victim policy: 0 least recently used, 1 pseudo-random |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_va | input | 14 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the request |
| lk_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| lk_write | input | 1 | 1 = write access, 0 = read |
| rsp_hit | output | 1 | Translation valid |
| rsp_miss | output | 1 | No matching entry; start a walk |
| rsp_fault | output | 1 | Matching entry forbids this access |
| rsp_pa | output | 12 | Physical address (0 unless hit) |
| fill_valid | input | 1 | Fill offered by the walker |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_va | input | 14 | Virtual address of the page being filled |
| fill_asid | input | 8 | Identifier of the filled mapping |
| fill_ppn | input | 6 | Physical page number |
| fill_perm | input | 3 | {supervisor-only, write allowed, read allowed} |
| inv_valid | input | 1 | Invalidate command |
| inv_all | input | 1 | 1 = remove all entries, 0 = only those of `inv_asid` |
| inv_asid | input | 8 | Identifier to remove when `inv_all` is 0 |

## Verification
The hardest case to reach from the ports is the victim choice in a full set after hits have reordered the recency. Random traffic seldom fills one set completely and then touches its ways in a known order. The stimulus therefore clears the cache, fills the four ways of one set with chosen tags, hits one of them, and then fills a fifth tag to see which entry is gone. Random traffic uses a small pool of pages and identifiers, so sets overflow often. This traffic is compared each cycle against a bench model of the same policy. Random-mode replacement cannot be predicted, so it is checked by counting which entries of the set survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic sup;
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= {{(W-1){1'b0}}, 1'b1};
    else        q <= {q[W-2:0], ^(q & TAPS)};
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0); // R9
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SW = $clog2(SETS),
  localparam int AW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [SW-1:0] touch_set,
  input  logic [AW-1:0] touch_way,
  input  logic [SW-1:0] vic_set,
  output logic [AW-1:0] vic_way
);
  logic [AW-1:0] age [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age[s][w] <= AW'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AW'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    vic_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[vic_set][w] == AW'(WAYS - 1)) vic_way = AW'(w);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    logic [WAYS-1:0] seen;
    always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[age[s][w]] = 1'b1;
    end
    AST_LRU_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      seen == {WAYS{1'b1}}); // R8
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int ASID_W = 8,
  localparam int AW = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid [WAYS],
  input  logic [TAG_W-1:0]  tag   [WAYS],
  input  logic [ASID_W-1:0] asid  [WAYS],
  input  logic [TAG_W-1:0]  q_tag,
  input  logic [ASID_W-1:0] q_asid,
  output logic              hit,
  output logic [AW-1:0]     hit_way,
  output logic              free,
  output logic [AW-1:0]     free_way
);
  logic [WAYS-1:0] m;

  always_comb begin
    hit = 1'b0; hit_way = '0; free = 1'b0; free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      m[w] = valid[w] && tag[w] == q_tag && asid[w] == q_asid;
      if (m[w]) begin hit = 1'b1; hit_way = AW'(w); end
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid[w]) begin free = 1'b1; free_way = AW'(w); end
  end

  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m) <= 1); // R6
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int OFF_W  = 6,
  parameter int PPN_W  = 6,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int ASID_W = 8,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int SW    = $clog2(SETS),
  localparam int AW    = $clog2(WAYS),
  localparam int TAG_W = VA_W - OFF_W - SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              repl_random,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_user,
  input  logic              lk_write,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_pa,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [2:0]        fill_perm,
  input  logic              inv_valid,
  input  logic              inv_all,
  input  logic [ASID_W-1:0] inv_asid
);
  logic              e_valid [SETS][WAYS];
  logic [TAG_W-1:0]  e_tag   [SETS][WAYS];
  logic [ASID_W-1:0] e_asid  [SETS][WAYS];
  logic [PPN_W-1:0]  e_ppn   [SETS][WAYS];
  perm_t             e_perm  [SETS][WAYS];

  logic [SW-1:0]    lk_set, f_set;
  logic [TAG_W-1:0] lk_tag, f_tag;
  assign lk_set = lk_va[OFF_W +: SW];
  assign lk_tag = lk_va[OFF_W + SW +: TAG_W];
  assign f_set  = fill_va[OFF_W +: SW];
  assign f_tag  = fill_va[OFF_W + SW +: TAG_W];

  logic          l_hit, l_free, f_hit, f_free;
  logic [AW-1:0] l_way, l_fway, f_way, f_fway, lru_way, vic_way;
  logic [7:0]    rnd;

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) i_lk_match (
    .clk, .rst_n, .valid(e_valid[lk_set]), .tag(e_tag[lk_set]),
    .asid(e_asid[lk_set]), .q_tag(lk_tag), .q_asid(lk_asid),
    .hit(l_hit), .hit_way(l_way), .free(l_free), .free_way(l_fway));

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) i_fill_match (
    .clk, .rst_n, .valid(e_valid[f_set]), .tag(e_tag[f_set]),
    .asid(e_asid[f_set]), .q_tag(f_tag), .q_asid(fill_asid),
    .hit(f_hit), .hit_way(f_way), .free(f_free), .free_way(f_fway));

  tlb_lfsr #(.W(8), .TAPS(8'hB8)) i_lfsr (.clk, .rst_n, .q(rnd));

  // Lookup: permission check on the matching way
  perm_t l_perm;
  logic  l_deny, do_fill, touch_hit;
  assign l_perm    = e_perm[lk_set][l_way];
  assign l_deny    = (lk_user && l_perm.sup) || (lk_write ? !l_perm.wr : !l_perm.rd);
  assign lk_ready  = 1'b1;
  assign rsp_hit   = lk_valid && l_hit && !l_deny;
  assign rsp_fault = lk_valid && l_hit && l_deny;
  assign rsp_miss  = lk_valid && !l_hit;
  assign rsp_pa    = rsp_hit ? {e_ppn[lk_set][l_way], lk_va[OFF_W-1:0]} : '0;

  // Fill: existing entry, else lowest free way, else policy victim
  assign fill_ready = !inv_valid;
  assign do_fill    = fill_valid && fill_ready;
  assign vic_way    = f_hit  ? f_way  :
                      f_free ? f_fway :
                      repl_random ? rnd[AW-1:0] : lru_way;
  assign touch_hit  = rsp_hit && !do_fill;

  tlb_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk, .rst_n,
    .touch_en(do_fill || touch_hit),
    .touch_set(do_fill ? f_set : lk_set),
    .touch_way(do_fill ? vic_way : l_way),
    .vic_set(f_set), .vic_way(lru_way));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          e_valid[s][w] <= 1'b0;
          e_tag[s][w]   <= '0;
          e_asid[s][w]  <= '0;
          e_ppn[s][w]   <= '0;
          e_perm[s][w]  <= '0;
        end
    end else if (inv_valid) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (inv_all || e_asid[s][w] == inv_asid) e_valid[s][w] <= 1'b0;
    end else if (do_fill) begin
      e_valid[f_set][vic_way] <= 1'b1;
      e_tag[f_set][vic_way]   <= f_tag;
      e_asid[f_set][vic_way]  <= fill_asid;
      e_ppn[f_set][vic_way]   <= fill_ppn;
      e_perm[f_set][vic_way]  <= fill_perm;
    end
  end

  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) any_valid |= e_valid[s][w];
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault})); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R5
  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_valid && inv_all) |-> !any_valid); // R10
  AST_FILL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && !lk_valid) |=> !(lk_valid && lk_va == $past(fill_va)
                                 && lk_asid == $past(fill_asid)) || !rsp_miss); // R6
endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        repl_random = 0, lk_valid = 0, lk_user = 0, lk_write = 0;
  logic [13:0] lk_va = 0, fill_va = 0;
  logic [7:0]  lk_asid = 0, fill_asid = 0, inv_asid = 0;
  logic        fill_valid = 0, inv_valid = 0, inv_all = 0;
  logic [5:0]  fill_ppn = 0;
  logic [2:0]  fill_perm = 0;
  logic        lk_ready, rsp_hit, rsp_miss, rsp_fault, fill_ready;
  logic [11:0] rsp_pa;

  tlb_xlate i_tlb_xlate (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  bit       m_v [4][4];
  bit [5:0] m_tag [4][4], m_ppn [4][4];
  bit [7:0] m_asid [4][4];
  bit [2:0] m_perm [4][4];
  int       m_age [4][4];
  bit       model_on = 1;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int find(bit [13:0] va, bit [7:0] a);
    for (int w = 0; w < 4; w++)
      if (m_v[va[7:6]][w] && m_tag[va[7:6]][w] == va[13:8] && m_asid[va[7:6]][w] == a)
        return w;
    return -1;
  endfunction

  // 0 idle, 1 hit, 2 miss, 3 fault
  function automatic int exp_cls(bit v, bit [13:0] va, bit [7:0] a, bit u, bit wr);
    int w;
    bit [2:0] p;
    if (!v) return 0;
    w = find(va, a);
    if (w < 0) return 2;
    p = m_perm[va[7:6]][w];
    if ((u && p[2]) || (wr ? !p[1] : !p[0])) return 3;
    return 1;
  endfunction

  function automatic void touch(int s, int w);
    int a0 = m_age[s][w];
    for (int k = 0; k < 4; k++)
      if (k == w) m_age[s][k] = 0;
      else if (m_age[s][k] < a0) m_age[s][k]++;
  endfunction

  function automatic void model_reset();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_age[s][w] = w; end
  endfunction

  function automatic void model_edge();
    int cls, w, s;
    cls = exp_cls(lk_valid, lk_va, lk_asid, lk_user, lk_write);
    if (inv_valid) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          if (inv_all || m_asid[i][j] == inv_asid) m_v[i][j] = 0;
    end else if (fill_valid) begin
      s = fill_va[7:6];
      w = find(fill_va, fill_asid);
      if (w < 0) for (int k = 3; k >= 0; k--) if (!m_v[s][k]) w = k;
      if (w < 0) for (int k = 0; k < 4; k++) if (m_age[s][k] == 3) w = k;
      m_v[s][w] = 1; m_tag[s][w] = fill_va[13:8]; m_asid[s][w] = fill_asid;
      m_ppn[s][w] = fill_ppn; m_perm[s][w] = fill_perm;
      touch(s, w);
    end
    if (!fill_valid || inv_valid)
      if (cls == 1) touch(lk_va[7:6], find(lk_va, lk_asid));
  endfunction

  function automatic int dut_cls();
    if (rsp_hit) return 1;
    if (rsp_miss) return 2;
    if (rsp_fault) return 3;
    return 0;
  endfunction

  // one cycle: inputs already set at negedge; check, then edge
  task automatic cyc(string req);
    int ec, w;
    bit [11:0] epa;
    #4;
    if (model_on) begin
      ec = exp_cls(lk_valid, lk_va, lk_asid, lk_user, lk_write);
      chk(dut_cls() == ec, req, dut_cls(), ec);
      if (ec == 1) begin
        w = find(lk_va, lk_asid);
        epa = {m_ppn[lk_va[7:6]][w], lk_va[5:0]};
        chk(rsp_pa == epa, req, rsp_pa, epa);
      end
      chk(fill_ready == !inv_valid, "R12", fill_ready, !inv_valid);
    end
    @(posedge clk);
    if (model_on) model_edge();
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; inv_valid = 0;
  endtask

  task automatic look(bit [13:0] va, bit [7:0] a, bit u, bit wr);
    lk_valid = 1; lk_va = va; lk_asid = a; lk_user = u; lk_write = wr;
  endtask

  task automatic fill(bit [13:0] va, bit [7:0] a, bit [5:0] ppn, bit [2:0] p);
    fill_valid = 1; fill_va = va; fill_asid = a; fill_ppn = ppn; fill_perm = p;
  endtask

  task automatic inval(bit all, bit [7:0] a);
    inv_valid = 1; inv_all = all; inv_asid = a;
  endtask

  task automatic expect_look(bit [13:0] va, bit [7:0] a, bit u, bit wr,
                             int cls, bit [11:0] pa, string req);
    look(va, a, u, wr);
    #4;
    chk(dut_cls() == cls, req, dut_cls(), cls);
    if (cls == 1) chk(rsp_pa == pa, req, rsp_pa, pa);
    @(posedge clk);
    if (model_on) model_edge();
    @(negedge clk);
    lk_valid = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED1);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 / R5 reset state
    #4;
    chk(lk_ready == 1, "R5", lk_ready, 1);
    chk(dut_cls() == 0, "R5", dut_cls(), 0);
    @(negedge clk);
    expect_look(14'h03D7, 8'h01, 0, 0, 2, 0, "R1");

    // R2 worked example
    fill(14'h03D7, 8'h01, 6'h0D, 3'b011); cyc("R6");
    expect_look(14'h03D7, 8'h01, 1, 0, 1, 12'h357, "R2");
    // R3 other ASID misses, then coexists
    expect_look(14'h03D7, 8'h02, 1, 0, 2, 0, "R3");
    fill(14'h03D7, 8'h02, 6'h22, 3'b011); cyc("R3");
    expect_look(14'h03D7, 8'h02, 1, 0, 1, {6'h22, 6'h17}, "R3");
    expect_look(14'h03D7, 8'h01, 1, 1, 1, 12'h357, "R3");

    // R4 permissions: supervisor-only read-only page
    fill(14'h1A45, 8'h01, 6'h3C, 3'b101); cyc("R4");
    expect_look(14'h1A45, 8'h01, 1, 0, 3, 0, "R4");
    expect_look(14'h1A45, 8'h01, 0, 0, 1, {6'h3C, 6'h05}, "R4");
    expect_look(14'h1A45, 8'h01, 0, 1, 3, 0, "R4");
    fill(14'h2B80, 8'h01, 6'h01, 3'b010); cyc("R4");
    expect_look(14'h2B80, 8'h01, 1, 0, 3, 0, "R4");
    expect_look(14'h2B80, 8'h01, 1, 1, 1, {6'h01, 6'h00}, "R4");

    // R6 refill in place
    fill(14'h03D7, 8'h01, 6'h11, 3'b011); cyc("R6");
    expect_look(14'h03D0, 8'h01, 1, 0, 1, {6'h11, 6'h10}, "R6");

    // R12 fill blocked by invalidate
    fill(14'h3FC0, 8'h07, 6'h2A, 3'b011); inval(0, 8'h55); cyc("R12");
    expect_look(14'h3FC0, 8'h07, 0, 0, 2, 0, "R12");

    // R11 invalidate one ASID
    inval(0, 8'h02); cyc("R11");
    expect_look(14'h03D7, 8'h02, 1, 0, 2, 0, "R11");
    expect_look(14'h03D7, 8'h01, 1, 0, 1, {6'h11, 6'h17}, "R11");

    // R10 invalidate all
    inval(1, 0); cyc("R10");
    expect_look(14'h03D7, 8'h01, 1, 0, 2, 0, "R10");
    expect_look(14'h1A45, 8'h01, 0, 0, 2, 0, "R10");

    // R7 / R8 in set 0: tags 1..4 fill ways 0..3, hit tag 1, then tag 5 evicts tag 2
    for (int t = 1; t <= 4; t++) begin
      fill({6'(t), 2'b00, 6'h00}, 8'h09, 6'(t + 8), 3'b011); cyc("R7");
    end
    for (int t = 1; t <= 4; t++)
      expect_look({6'(t), 2'b00, 6'h21}, 8'h09, 1, 0, 1, {6'(t + 8), 6'h21}, "R7");
    expect_look({6'd1, 2'b00, 6'h00}, 8'h09, 1, 0, 1, {6'd9, 6'h00}, "R8");
    fill({6'd5, 2'b00, 6'h00}, 8'h09, 6'd13, 3'b011); cyc("R8");
    expect_look({6'd1, 2'b00, 6'h00}, 8'h09, 1, 0, 1, {6'd9, 6'h00}, "R8");
    expect_look({6'd2, 2'b00, 6'h00}, 8'h09, 1, 0, 2, 0, "R8");
    expect_look({6'd5, 2'b00, 6'h00}, 8'h09, 1, 0, 1, {6'd13, 6'h00}, "R8");

    // constrained random against the model, LRU policy
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 60)
        look({3'b0, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 6'($urandom)},
             8'($urandom_range(1, 3)), 1'($urandom), 1'($urandom));
      if (r >= 30 && r < 85)
        fill({3'b0, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 6'h00},
             8'($urandom_range(1, 3)), 6'($urandom), 3'($urandom));
      if (r >= 95) inval($urandom_range(0, 3) == 0, 8'($urandom_range(1, 3)));
      cyc("R8");
    end

    // R9 random replacement in set 1
    inval(1, 0); cyc("R10");
    model_on = 0;
    repl_random = 1;
    for (int t = 0; t < 4; t++) begin
      fill({6'(t + 20), 2'b01, 6'h00}, 8'h04, 6'(t), 3'b011); cyc("R9");
    end
    repeat (int'($urandom_range(1, 9))) cyc("R9");
    fill({6'd40, 2'b01, 6'h00}, 8'h04, 6'h30, 3'b011); cyc("R9");
    begin
      int kept = 0;
      for (int t = 0; t < 4; t++) begin
        look({6'(t + 20), 2'b01, 6'h00}, 8'h04, 0, 0);
        #4; if (rsp_hit) kept++;
        @(negedge clk); lk_valid = 0;
      end
      chk(kept == 3, "R9", kept, 3);
      look({6'd40, 2'b01, 6'h07}, 8'h04, 0, 0);
      #4;
      chk(rsp_hit && rsp_pa == {6'h30, 6'h07}, "R9", rsp_pa, {6'h30, 6'h07});
      @(negedge clk); lk_valid = 0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule